// File: doc/BRIEF.md
# Predicated saturating vector multiply-high

This block is a 128-bit SIMD datapath. It takes two source vectors and treats them as signed lanes of 8, 16 or 32 bits. For each lane pair it forms a doubled product and keeps the high half of that product. A single control bit picks one of two forms. The truncating form discards the low bits. The rounding form adds half of one result unit before it shifts. Each lane result is clamped to the signed range of its element width.

The lane results are merged byte by byte into the previous destination vector under a 16-bit per-byte predicate mask. A byte whose mask bit is clear keeps its old value. A sticky cumulative-saturation flag records any clamp that happened in an active lane. A lane counts as active when the mask bit of its lowest byte is set. The flag stays set until the dedicated clear input is asserted.

The arithmetic is combinational, followed by one register stage. A pulse on `start` captures the operands. The merged result and a one-cycle `valid` pulse appear on the next clock.

Top module: `sat_mulhi_unit`

## Requirements
- R1: `esize` selects the lane width. 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, and 2 or 3 give four 32-bit lanes. Lane k of width W occupies bits [k*W+W-1 : k*W].
- R2: With `round_sel` = 0, each lane result is floor(a*b / 2^(W-1)), where a and b are the signed lane values. This is an arithmetic right shift of the product.
- R3: With `round_sel` = 1, each lane result is floor((a*b + 2^(W-2)) / 2^(W-1)).
- R4: A lane value above 2^(W-1)-1 or below -2^(W-1) is clamped to that bound, and the lane is then saturated. The only such case is both operands equal to the most negative value, which gives the most positive value.
- R5: Byte i of `result` takes the computed byte when `pred[i]` = 1. When `pred[i]` = 0, it takes byte i of `dst_old`.
- R6: An operation sets `sat_flag` only if some lane saturates and that lane's lowest-byte mask bit is 1. Saturation in an inactive lane leaves the flag unchanged.
- R7: `sat_flag` is sticky and no operation clears it. `sat_clr` = 1 clears it on the next edge. If an operation that sets the flag occurs in the same cycle as `sat_clr`, the set wins.
- R8: `result` and `valid` = 1 appear one clock after `start` = 1. `valid` is 0 in a cycle that follows `start` = 0. `result` holds its value while no operation is started.
- R9: While `rst_n` = 0 at a clock edge, `result`, `valid` and `sat_flag` are all cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch an operation with the current operands |
| round_sel | input | 1 | 0 truncating form, 1 rounding form |
| esize | input | 2 | Lane width select (0: 8, 1: 16, 2/3: 32 bits) |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| dst_old | input | 128 | Previous destination vector |
| pred | input | 16 | Per-byte predicate mask |
| sat_clr | input | 1 | Clear the sticky saturation flag |
| result | output | 128 | Merged destination vector |
| valid | output | 1 | One-cycle pulse marking a new result |
| sat_flag | output | 1 | Sticky cumulative-saturation flag |

## Verification
The bench targets the case where both operands are the most negative lane value, at every width. A design with no clamp would return the most negative value instead of the most positive one, and its flag would stay clear. The bench also places a saturating lane under a mask that leaves only its upper bytes active. A design that took activity from the wrong byte would set the flag there, and it would also write the masked-off low bytes. Further tests cover rounding at odd products, the encoding `esize` = 3, a clear in the same cycle as a saturating operation, and holding the result between operations. These expose a shifter with the wrong rounding constant, a missing width decode, clear-over-set priority, and a register that loads on every cycle.

// File: rtl/sat_mulhi_pkg.sv
// Package: shared sizes and the lane-width encoding of the multiply-high unit.
// Assumes byte-granular predication over a vector that is a multiple of 32 bits.
package sat_mulhi_pkg;
    localparam int BYTE_W = 8;
    localparam int NUM_SIZES = 3;

    typedef enum logic [1:0] {
        ESZ_8   = 2'd0,
        ESZ_16  = 2'd1,
        ESZ_32  = 2'd2,
        ESZ_32X = 2'd3
    } esize_e;
endpackage

// File: rtl/sat_mulhi_lane.sv
// Module: one signed lane of the saturating doubling multiply-high.
// Computes (a*b [+ 2^(W-2)]) >>> (W-1), clamps to W-bit signed range and
// flags the clamp. Assumes W >= 8. Purely combinational.
module sat_mulhi_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         rnd,
    output logic [W-1:0] r,
    output logic         sat
);
    localparam int PW = 2 * W + 1;
    localparam logic signed [PW-1:0] ONE   = PW'(1);
    localparam logic signed [PW-1:0] RND_K = ONE <<< (W - 2);
    localparam logic signed [PW-1:0] MAXV  = (ONE <<< (W - 1)) - ONE;
    localparam logic signed [PW-1:0] MINV  = -(ONE <<< (W - 1));

    logic signed [PW-1:0] ax, bx, prod, biased, shifted;

    // Purpose: widen operands, multiply, add rounding constant, shift, clamp.
    always_comb begin
        ax      = PW'($signed(a));
        bx      = PW'($signed(b));
        prod    = ax * bx;
        biased  = prod + (rnd ? RND_K : '0);
        shifted = biased >>> (W - 1);
        if (shifted > MAXV) begin
            r   = MAXV[W-1:0];
            sat = 1'b1;
        end else if (shifted < MINV) begin
            r   = MINV[W-1:0];
            sat = 1'b1;
        end else begin
            r   = shifted[W-1:0];
            sat = 1'b0;
        end
    end
endmodule

// File: rtl/sat_mulhi_lanes.sv
// Module: lane arrays for every supported width and selection by esize.
// Each width has its own array of lane units; the selected one drives the
// output. Saturation is reported on the lowest byte of each lane.
module sat_mulhi_lanes
    import sat_mulhi_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0]        a,
    input  logic [VEC_W-1:0]        b,
    input  logic                    rnd,
    input  esize_e                  esize,
    output logic [VEC_W-1:0]        res,
    output logic [VEC_W/BYTE_W-1:0] sat_byte
);
    localparam int NBYTES = VEC_W / BYTE_W;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : gen_sz
        localparam int W     = BYTE_W << g;
        localparam int NB    = W / BYTE_W;
        localparam int LANES = VEC_W / W;
        logic [VEC_W-1:0]  rv;
        logic [NBYTES-1:0] sv;
        for (genvar l = 0; l < LANES; l++) begin : gen_lane
            logic s;
            sat_mulhi_lane #(.W(W)) u_lane (
                .a   (a[l*W +: W]),
                .b   (b[l*W +: W]),
                .rnd (rnd),
                .r   (rv[l*W +: W]),
                .sat (s)
            );
            assign sv[l*NB +: NB] = NB'(s);
        end
    end

    // Purpose: pick the lane array that matches the requested width.
    always_comb begin
        unique case (esize)
            ESZ_8:   begin res = gen_sz[0].rv; sat_byte = gen_sz[0].sv; end
            ESZ_16:  begin res = gen_sz[1].rv; sat_byte = gen_sz[1].sv; end
            default: begin res = gen_sz[2].rv; sat_byte = gen_sz[2].sv; end
        endcase
    end
endmodule

// File: rtl/sat_mulhi_merge.sv
// Module: per-byte predicated merge and active-lane saturation detect.
// Assumes sat_byte is set only on the lowest byte of a saturated lane.
module sat_mulhi_merge #(
    parameter int NBYTES = 16,
    parameter int BW     = 8
) (
    input  logic [NBYTES*BW-1:0] fresh,
    input  logic [NBYTES*BW-1:0] old,
    input  logic [NBYTES-1:0]    pred,
    input  logic [NBYTES-1:0]    sat_byte,
    output logic [NBYTES*BW-1:0] merged,
    output logic                 any_sat
);
    for (genvar i = 0; i < NBYTES; i++) begin : gen_byte
        assign merged[i*BW +: BW] = pred[i] ? fresh[i*BW +: BW] : old[i*BW +: BW];
    end

    // Purpose: a saturation counts only when its lane's lowest byte is active.
    assign any_sat = |(sat_byte & pred);
endmodule

// File: rtl/sat_mulhi_unit.sv
// Module: top of the predicated saturating vector multiply-high unit.
// Combinational lane math and merge, one register stage for the result,
// a valid pulse and a sticky saturation flag. Synchronous active-low reset.
module sat_mulhi_unit
    import sat_mulhi_pkg::*;
#(
    parameter int VEC_W = 128,
    localparam int NBYTES = VEC_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              round_sel,
    input  logic [1:0]        esize,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [VEC_W-1:0]  dst_old,
    input  logic [NBYTES-1:0] pred,
    input  logic              sat_clr,
    output logic [VEC_W-1:0]  result,
    output logic              valid,
    output logic              sat_flag
);
    logic [VEC_W-1:0]  lane_res, merged;
    logic [NBYTES-1:0] sat_byte;
    logic              any_sat;

    sat_mulhi_lanes #(.VEC_W(VEC_W)) u_lanes (
        .a        (src_a),
        .b        (src_b),
        .rnd      (round_sel),
        .esize    (esize_e'(esize)),
        .res      (lane_res),
        .sat_byte (sat_byte)
    );

    sat_mulhi_merge #(.NBYTES(NBYTES), .BW(BYTE_W)) u_merge (
        .fresh    (lane_res),
        .old      (dst_old),
        .pred     (pred),
        .sat_byte (sat_byte),
        .merged   (merged),
        .any_sat  (any_sat)
    );

    // Purpose: capture the merged vector on start and pulse valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= start;
            if (start) begin
                result <= merged;
            end
        end
    end

    // Purpose: sticky saturation flag; clear input, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sat_flag <= 1'b0;
        end else begin
            sat_flag <= (sat_flag & ~sat_clr) | (start & any_sat);
        end
    end
endmodule

// File: rtl/sat_mulhi_checker.sv
// Module: temporal checks on the multiply-high unit, bound to its top.
// Assumes the synchronous active-low reset of the unit.
module sat_mulhi_checker #(
    parameter int VEC_W = 128,
    parameter int NBYTES = VEC_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [VEC_W-1:0]  dst_old,
    input logic [NBYTES-1:0] pred,
    input logic              sat_clr,
    input logic [VEC_W-1:0]  result,
    input logic              valid,
    input logic              sat_flag
);
    // R8: valid follows start by one cycle
    assert_valid_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    assert_no_spurious_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    // R8: result holds between operations
    assert_result_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));
    // R7: flag is never dropped without a clear
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !sat_clr) |=> sat_flag);
    // R7: a clear with no operation empties the flag
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_clr && !start) |=> !sat_flag);
    // R6: without an operation the flag cannot rise
    assert_no_set_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !sat_flag) |=> !sat_flag);

    for (genvar i = 0; i < NBYTES; i++) begin : gen_keep
        // R5: inactive bytes keep the old destination value
        assert_masked_byte_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (start && !pred[i]) |=> (result[i*8 +: 8] == $past(dst_old[i*8 +: 8])));
    end
endmodule

bind sat_mulhi_unit sat_mulhi_checker #(.VEC_W(VEC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dst_old  (dst_old),
    .pred     (pred),
    .sat_clr  (sat_clr),
    .result   (result),
    .valid    (valid),
    .sat_flag (sat_flag)
);

// File: tb/tb_sat_mulhi_unit.sv
`timescale 1ns/1ps
module tb_sat_mulhi_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         round_sel = 1'b0;
    logic [1:0]   esize = 2'd0;
    logic [127:0] src_a = '0, src_b = '0, dst_old = '0;
    logic [15:0]  pred = '0;
    logic         sat_clr = 1'b0;
    logic [127:0] result;
    logic         valid;
    logic         sat_flag;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic exp_flag = 1'b0;

    always #2.5 clk = ~clk;

    sat_mulhi_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .round_sel(round_sel),
        .esize(esize), .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
        .pred(pred), .sat_clr(sat_clr), .result(result), .valid(valid),
        .sat_flag(sat_flag)
    );

    typedef struct packed {
        logic [1:0]   esz;
        logic         rnd;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] old;
        logic [15:0]  pr;
    } stim_t;

    // R1 R2 R3 R4 R5 R6: mixed widths, forms, masks and operand patterns
    localparam stim_t TABLE [10] = '{
        '{2'd0, 1'b0, 128'h01027f80ff104040c0c080017f7f80ff, 128'h7f7f02803c10c040c040ff017f81807f, 128'haaaaaaaaaaaaaaaaaaaaaaaaaaaaaaaa, 16'hffff},
        '{2'd0, 1'b1, 128'h01027f80ff104040c0c080017f7f80ff, 128'h7f7f02803c10c040c040ff017f81807f, 128'h5555555555555555555555555555555a, 16'hffff},
        '{2'd1, 1'b0, 128'h8000123456787fffc0008001ffff0001, 128'h80007fff9abc7fff4000800100011234, 128'h00000000000000000000000000000000, 16'hffff},
        '{2'd1, 1'b1, 128'h8000123456787fffc0008001ffff0001, 128'h80007fff9abc7fff4000800100011234, 128'h11111111111111111111111111111111, 16'h0ff0},
        '{2'd2, 1'b0, 128'h800000007fffffff12345678c0000001, 128'h8000000080000000fedcba9840000001, 128'hdeadbeefdeadbeefdeadbeefdeadbeef, 16'hffff},
        '{2'd2, 1'b1, 128'h800000007fffffff12345678c0000001, 128'h8000000080000000fedcba9840000001, 128'hcafef00dcafef00dcafef00dcafef00d, 16'h3c3c},
        '{2'd0, 1'b1, 128'h0303030303030303fdfdfdfdfdfdfdfd, 128'h21212121212121212121212121212121, 128'h0, 16'h5a5a},
        '{2'd1, 1'b1, 128'h0003fffd0003fffd00010001ffffffff, 128'h20002000e000e000400040004000c000, 128'hffffffffffffffffffffffffffffffff, 16'hffff},
        '{2'd2, 1'b1, 128'h00000003fffffffd0000000100000001, 128'h200000002000000040000000c0000000, 128'h0, 16'hffff},
        '{2'd0, 1'b0, 128'h0, 128'hffffffffffffffffffffffffffffffff, 128'h0123456789abcdef0123456789abcdef, 16'h0000}
    };

    // Reference from the requirements: returns {saturated-active, merged vector}.
    function automatic logic [128:0] model(logic [1:0] esz, logic rnd,
                                           logic [127:0] a, logic [127:0] b,
                                           logic [127:0] old, logic [15:0] pr);
        int nb;
        int w;
        logic [127:0] r;
        logic s;
        longint av, bv, p, mx, mn;
        bit lsat;
        nb = (esz == 2'd0) ? 1 : (esz == 2'd1) ? 2 : 4;
        w  = 8 * nb;
        r  = old;
        s  = 1'b0;
        for (int L = 0; L < 16 / nb; L++) begin
            av = 0;
            bv = 0;
            for (int k = 0; k < nb; k++) begin
                av = av | (longint'(a[(L*nb+k)*8 +: 8]) << (8*k));
                bv = bv | (longint'(b[(L*nb+k)*8 +: 8]) << (8*k));
            end
            if (av >= (64'sd1 <<< (w-1))) av = av - (64'sd1 <<< w);
            if (bv >= (64'sd1 <<< (w-1))) bv = bv - (64'sd1 <<< w);
            p = av * bv;
            if (rnd) p = p + (64'sd1 <<< (w-2));
            p = p >>> (w-1);
            mx = (64'sd1 <<< (w-1)) - 1;
            mn = -mx - 1;
            lsat = 1'b0;
            if (p > mx) begin p = mx; lsat = 1'b1; end
            if (p < mn) begin p = mn; lsat = 1'b1; end
            if (lsat && pr[L*nb]) s = 1'b1;
            for (int k = 0; k < nb; k++) begin
                if (pr[L*nb+k]) r[(L*nb+k)*8 +: 8] = p[8*k +: 8];
            end
        end
        return {s, r};
    endfunction

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Launch one operation; outputs are checked one cycle later at negedge.
    task automatic run_op(string tag, logic [1:0] esz, logic rnd, logic [127:0] a,
                          logic [127:0] b, logic [127:0] old, logic [15:0] pr,
                          logic clr);
        logic [128:0] m;
        m = model(esz, rnd, a, b, old, pr);
        @(negedge clk);
        esize = esz; round_sel = rnd; src_a = a; src_b = b;
        dst_old = old; pred = pr; sat_clr = clr; start = 1'b1;
        exp_flag = (exp_flag & ~clr) | m[128];
        @(negedge clk);
        start = 1'b0;
        sat_clr = 1'b0;
        chk({tag, " result"}, result, m[127:0]);
        chk({tag, " valid"}, 128'(valid), 128'd1);
        chk({tag, " flag"}, 128'(sat_flag), 128'(exp_flag));
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 result", result, 128'd0);
        chk("R9 valid", 128'(valid), 128'd0);
        chk("R9 flag", 128'(sat_flag), 128'd0);
        rst_n = 1'b1;

        for (int i = 0; i < 10; i++) begin
            run_op($sformatf("R2 R3 R5 table[%0d]", i), TABLE[i].esz, TABLE[i].rnd,
                   TABLE[i].a, TABLE[i].b, TABLE[i].old, TABLE[i].pr, 1'b0);
        end

        // R7: clear with no operation
        @(negedge clk);
        sat_clr = 1'b1;
        @(negedge clk);
        sat_clr = 1'b0;
        exp_flag = 1'b0;
        chk("R7 clear", 128'(sat_flag), 128'd0);

        // R6: saturating 16-bit lanes whose low bytes are masked off
        run_op("R6 inactive sat", 2'd1, 1'b0, {8{16'h8000}}, {8{16'h8000}},
               {16{8'h33}}, 16'haaaa, 1'b0);
        chk("R6 inactive flag", 128'(sat_flag), 128'd0);
        chk("R6 inactive bytes", result, {8{16'h7f33}});

        // R4: 8-bit most-negative squared gives most positive, flag set
        run_op("R4 sat8", 2'd0, 1'b0, {16{8'h80}}, {16{8'h80}}, '0, 16'hffff, 1'b0);
        chk("R4 sat8 value", result, {16{8'h7f}});
        chk("R4 sat8 flag", 128'(sat_flag), 128'd1);

        // R7: sticky through a non-saturating op
        run_op("R7 sticky", 2'd1, 1'b1, {8{16'h0100}}, {8{16'h0100}}, '0, 16'hffff, 1'b0);
        chk("R7 sticky flag", 128'(sat_flag), 128'd1);

        // R7: set wins over same-cycle clear
        run_op("R7 set wins", 2'd2, 1'b1, {4{32'h80000000}}, {4{32'h80000000}}, '0,
               16'h000f, 1'b1);
        chk("R7 set wins flag", 128'(sat_flag), 128'd1);
        chk("R4 sat32 value", result, {96'd0, 32'h7fffffff});

        // R7: clear together with a non-saturating op
        run_op("R7 clear with op", 2'd0, 1'b0, '0, '0, '0, 16'hffff, 1'b1);
        chk("R7 clear with op flag", 128'(sat_flag), 128'd0);

        // R1: encoding 3 acts as 32-bit lanes
        run_op("R1 esize3", 2'd3, 1'b0, {4{32'h40000000}}, {4{32'h00000003}}, '0,
               16'hffff, 1'b0);
        chk("R1 esize3 value", result, {4{32'h00000001}});

        // R3: rounding of 3*0x21 at 8 bits -> (99+64)>>7 = 1, truncating -> 0
        run_op("R3 round8", 2'd0, 1'b1, {16{8'h03}}, {16{8'h21}}, '0, 16'hffff, 1'b0);
        chk("R3 round8 value", result, {16{8'h01}});
        run_op("R2 trunc8", 2'd0, 1'b0, {16{8'h03}}, {16{8'h21}}, '0, 16'hffff, 1'b0);
        chk("R2 trunc8 value", result, {16{8'h00}});
        // R2: negative product floors: -3*0x21 = -99 -> -1
        run_op("R2 trunc8 neg", 2'd0, 1'b0, {16{8'hfd}}, {16{8'h21}}, '0, 16'hffff, 1'b0);
        chk("R2 trunc8 neg value", result, {16{8'hff}});

        // R8: valid drops and result holds with no start
        held = result;
        @(negedge clk);
        src_a = '1; src_b = '1; dst_old = '1; pred = 16'hffff;
        chk("R8 valid low", 128'(valid), 128'd0);
        @(negedge clk);
        chk("R8 result held", result, held);
        chk("R8 valid still low", 128'(valid), 128'd0);

        // R9: reset in mid-run clears everything
        run_op("R9 pre", 2'd0, 1'b0, {16{8'h80}}, {16{8'h80}}, '0, 16'hffff, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset result", result, 128'd0);
        chk("R9 reset flag", 128'(sat_flag), 128'd0);
        rst_n = 1'b1;
        exp_flag = 1'b0;

        finish_run();
    end
endmodule